// File: doc/BRIEF.md
# TFT panel strobe generator

This block produces the five periodic control strobes a segment-driven TFT panel needs at line and frame rate. It runs from one clock with a pixel-tick enable (`pix_ce`) and has one enable input (`en`). Counters advance only on pixel ticks. There are three counter groups: a two-line polarity-reversal counter, a line-pulse counter, and a group that drives the start pulse, the frame start pulse and the gate/clear signal. The line and frame indices come from the last group.

After enable the generators come up in a fixed staggered order. The reversal generator starts first. The line-pulse generator starts once the reversal counter has gone past 11. The last group starts once the line-pulse counter has reached 3. Dropping `en` stops every generator at the same edge and clears all state, so the next enable repeats the whole start sequence. With the default parameters the line period is 303 ticks, which is a 6 MHz tick divided by 60 frames and by 329 lines. The frame has 320 visible lines and 9 blanking lines.

In the requirements below, L is `CLK_PER_LINE` and T is `VIS_LINES + BLANK_LINES`. "Tick n" means the n-th clock edge with `pix_ce` high after the edge that first samples `en` high. That first edge is tick 0 and does not need `pix_ce`.

Top module: `tft_strobe_gen`

## Requirements
- R1: During reset, and from the first edge at which `en` is sampled low, the outputs are `rev_o`, `lp_o`, `sp_o`, `fs_o` and `running_o` at 0, `gc_n_o` at 1 (inactive), and both indices at 0.
- R2: `rev_o` is high after tick 0. From then on it is high for L ticks and low for L ticks, repeating with a period of 2L ticks.
- R3: `lp_o` is first high after tick 13, because the reversal counter has passed 11. It is then high for exactly one tick in every L ticks.
- R4: The start pulse `sp_o` is first high after tick 17, once the line-pulse counter has reached 3. It is then high for one tick in every L ticks.
- R5: `fs_o` is high for the first two line periods (2L ticks) of every frame of L*T ticks, counted from the start of the last group.
- R6: `gc_n_o` is active low and has the opposite polarity to the other strobes. It is low for the first `PIX_PER_LINE + BLANK_LINES - 1` ticks of every line of the last group (248 by default, 12 on the bench).
- R7: `line_idx_o` counts lines 0..T-1 of the last group and wraps to 0. `frame_idx_o` increments at each wrap and rolls over modulo 2^`FRAME_W`.
- R8: `running_o` rises at the same edge the last group starts (tick 17) and never before.
- R9: An edge with `pix_ce` low while enabled changes no counter. Every strobe and index holds its value.
- R10: A new enable after a disable restarts the full staggered sequence from tick 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| pix_ce | input | 1 | Pixel tick enable |
| rev_o | output | 1 | Polarity-reversal signal |
| lp_o | output | 1 | Line pulse |
| sp_o | output | 1 | Start pulse |
| fs_o | output | 1 | Frame start pulse |
| gc_n_o | output | 1 | Gate/clear signal, active low |
| running_o | output | 1 | All generators started |
| line_idx_o | output | $clog2(VIS_LINES+BLANK_LINES) | Current line index |
| frame_idx_o | output | FRAME_W | Frame counter |

## Verification
Two functions can fall in the same cycle: a pixel-tick stall, and a start threshold or line/frame wrap. When both land together, the stall must win, and the threshold must fire at the next real tick.

The bench provokes this by running with `pix_ce` removed on every third cycle, so stalls fall on the tick-12 and tick-16 threshold cycles and on frame wraps. It also drops `en` in the middle of a frame while the clock enable is low.

Each case is judged against a model that places every strobe only from the count of real ticks since enable.

// File: rtl/tft_strobe_gen.sv
module tft_strobe_gen #(
  parameter int CLK_PER_LINE = 303,
  parameter int VIS_LINES    = 320,
  parameter int BLANK_LINES  = 9,
  parameter int PIX_PER_LINE = 240,
  parameter int FRAME_W      = 8,
  parameter int REV_GATE     = 11,
  parameter int LINE_GATE    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pix_ce,
  output logic rev_o,
  output logic lp_o,
  output logic sp_o,
  output logic fs_o,
  output logic gc_n_o,
  output logic running_o,
  output logic [$clog2(VIS_LINES+BLANK_LINES)-1:0] line_idx_o,
  output logic [FRAME_W-1:0] frame_idx_o
);
  localparam int TOT_LINES = VIS_LINES + BLANK_LINES;
  localparam int GATE_LEN  = PIX_PER_LINE + BLANK_LINES - 1;
  localparam int CW = $clog2(2 * CLK_PER_LINE);
  localparam int RW = $clog2(TOT_LINES);
  localparam logic [CW-1:0] LINE_LAST = CW'(CLK_PER_LINE - 1);
  localparam logic [CW-1:0] REV_LAST  = CW'(2 * CLK_PER_LINE - 1);
  localparam logic [CW-1:0] HALF      = CW'(CLK_PER_LINE);
  localparam logic [CW-1:0] REV_THR   = CW'(REV_GATE);
  localparam logic [CW-1:0] LINE_THR  = CW'(LINE_GATE);
  localparam logic [CW-1:0] GATE_W    = CW'(GATE_LEN);
  localparam logic [RW-1:0] ROW_LAST  = RW'(TOT_LINES - 1);
  localparam logic [RW-1:0] FS_ROWS   = RW'(2);

  logic rev_on, lp_on, grp_on;
  logic [CW-1:0] rev_cnt, lp_cnt, grp_cnt;
  logic [RW-1:0] row;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_on <= 1'b0; lp_on <= 1'b0; grp_on <= 1'b0;
      rev_cnt <= '0; lp_cnt <= '0; grp_cnt <= '0;
      row <= '0; frame <= '0;
    end else if (!en) begin
      rev_on <= 1'b0; lp_on <= 1'b0; grp_on <= 1'b0;
      rev_cnt <= '0; lp_cnt <= '0; grp_cnt <= '0;
      row <= '0; frame <= '0;
    end else begin
      rev_on <= 1'b1;
      if (pix_ce) begin
        if (rev_on) rev_cnt <= (rev_cnt == REV_LAST) ? '0 : rev_cnt + 1'b1;
        if (rev_on && rev_cnt > REV_THR) lp_on <= 1'b1;
        if (lp_on) lp_cnt <= (lp_cnt == LINE_LAST) ? '0 : lp_cnt + 1'b1;
        if (lp_on && lp_cnt == LINE_THR) grp_on <= 1'b1;
        if (grp_on) begin
          if (grp_cnt == LINE_LAST) begin
            grp_cnt <= '0;
            if (row == ROW_LAST) begin
              row   <= '0;
              frame <= frame + 1'b1;
            end else begin
              row <= row + 1'b1;
            end
          end else begin
            grp_cnt <= grp_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign rev_o       = rev_on && (rev_cnt < HALF);
  assign lp_o        = lp_on && (lp_cnt == '0);
  assign sp_o        = grp_on && (grp_cnt == '0);
  assign fs_o        = grp_on && (row < FS_ROWS);
  assign gc_n_o      = !(grp_on && (grp_cnt < GATE_W));
  assign running_o   = grp_on;
  assign line_idx_o  = row;
  assign frame_idx_o = frame;

  AST_STOP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rev_o && !lp_o && !running_o && gc_n_o)); // R1
  AST_LP_AFTER_REV: assert property (@(posedge clk) disable iff (!rst_n)
    lp_on |-> rev_on); // R3
  AST_LP_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_o && pix_ce) |=> !lp_o); // R3
  AST_GROUP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> (lp_on && rev_on)); // R8
  AST_GATE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !gc_n_o |-> running_o); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pix_ce) |=> ($stable(rev_cnt) && $stable(lp_cnt) && $stable(grp_cnt) && $stable(row))); // R9
endmodule

// File: tb/sim_tft_strobe_gen.sv
`timescale 1ns/1ps
module sim_tft_strobe_gen;
  localparam int L  = 20;
  localparam int VL = 6;
  localparam int BL = 3;
  localparam int PX = 10;
  localparam int FW = 4;
  localparam int T  = VL + BL;
  localparam int GW = PX + BL - 1;
  localparam int RW = $clog2(T);

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pix_ce = 1'b0;
  logic rev_o, lp_o, sp_o, fs_o, gc_n_o, running_o;
  logic [RW-1:0] line_idx_o;
  logic [FW-1:0] frame_idx_o;

  tft_strobe_gen #(.CLK_PER_LINE(L), .VIS_LINES(VL), .BLANK_LINES(BL),
                   .PIX_PER_LINE(PX), .FRAME_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pix_ce(pix_ce),
    .rev_o(rev_o), .lp_o(lp_o), .sp_o(sp_o), .fs_o(fs_o), .gc_n_o(gc_n_o),
    .running_o(running_o), .line_idx_o(line_idx_o), .frame_idx_o(frame_idx_o));

  always #2.5 clk = ~clk;

  typedef struct {
    string ph;
    int rev, lp, sp, fs, gcn, run, line, frame;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int n = -1;
  string phase = "R1 reset";

  function automatic exp_t model(int k, string p);
    exp_t e;
    int g;
    e.ph = p; e.rev = 0; e.lp = 0; e.sp = 0; e.fs = 0;
    e.gcn = 1; e.run = 0; e.line = 0; e.frame = 0;
    if (k >= 0) e.rev = ((k % (2*L)) < L) ? 1 : 0;
    if (k >= 13) e.lp = (((k - 13) % L) == 0) ? 1 : 0;
    if (k >= 17) begin
      g = k - 17;
      e.sp = ((g % L) == 0) ? 1 : 0;
      e.fs = (((g / L) % T) < 2) ? 1 : 0;
      e.gcn = ((g % L) < GW) ? 0 : 1;
      e.run = 1;
      e.line = (g / L) % T;
      e.frame = (g / (L*T)) % (1 << FW);
    end
    return e;
  endfunction

  task automatic chk(string p, string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at %0t", p, tag, got, exp, $time);
    end
  endtask

  task automatic step(logic e, logic c);
    @(negedge clk);
    en = e; pix_ce = c;
    @(posedge clk);
    if (!rst_n || !e) n = -1;
    else if (n < 0) n = 0;
    else if (c) n++;
    #1 q.push_back(model(n, phase));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.ph, "R2 rev", int'(rev_o), e.rev);
        chk(e.ph, "R3 line pulse", int'(lp_o), e.lp);
        chk(e.ph, "R4 start pulse", int'(sp_o), e.sp);
        chk(e.ph, "R5 frame start", int'(fs_o), e.fs);
        chk(e.ph, "R6 gate/clear", int'(gc_n_o), e.gcn);
        chk(e.ph, "R8 running", int'(running_o), e.run);
        chk(e.ph, "R7 line index", int'(line_idx_o), e.line);
        chk(e.ph, "R7 frame index", int'(frame_idx_o), e.frame);
      end
    end
  end

  initial begin : watchdog
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    phase = "R1 idle";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    phase = "R2 R3 R4 R5 R6 R7 free run";
    for (int i = 0; i < 420; i++) step(1'b1, 1'b1);
    phase = "R1 disabled";
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    phase = "R9 R10 stalled restart";
    for (int i = 0; i < 330; i++) step(1'b1, (i % 3) != 0);
    phase = "R1 disable during stall";
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    phase = "R10 second restart";
    for (int i = 0; i < 60; i++) step(1'b1, 1'b1);
    phase = "R9 long stall";
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
    @(posedge clk);
    #4;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule